// File: doc/BRIEF.md
# Two-Beat Burst Memory with Separate Read and Write Ports

This block is a synchronous on-chip memory with independent read and write ports. Each port can start a command in the same clock cycle, and each command has its own address. Every transfer is a fixed burst of two data beats on a narrow bus. The storage array holds words that are twice the bus width, so one address selects a pair of beats.

On the write port, the command cycle carries the first data beat and the next cycle carries the second. Each beat has its own lane enables, one per 9-bit lane. The write collector holds the first beat and then commits both masked halves to the array in one operation, on the clock edge that ends the second beat. On the read port, one wide word is fetched in a single array access and registered. It is then sent out as the lower half followed by the upper half, with a valid flag.

A read that lands on the same address as a write whose second beat is on the bus in the fetch cycle is forwarded the merged, masked new data. It does not receive the stale array contents. Each port accepts a new command at most every second cycle.

Top module: `b2_sram`

## Requirements
- R1: During and after reset, `rd_valid` is low and `rd_data` is all zeros. `rd_data` is zero in every cycle in which `rd_valid` is low.
- R2: A write command in cycle N carries beat 0 on `wr_data` (the lower half of the word, bits W-1..0). Cycle N+1 carries beat 1 (the upper half). Both halves are committed to address `wr_addr` from cycle N in one array write.
- R3: `wr_be[i]` is sampled with each beat and gates bits 9*i+8..9*i of that beat. Lanes whose enable is low keep their previous contents.
- R4: A read command accepted in cycle N drives beat 0 (the lower half) on `rd_data` in cycle N+2 and beat 1 (the upper half) in cycle N+3. `rd_valid` is high in both of those cycles.
- R5: A read command and a write command in the same cycle, with different addresses, both complete correctly.
- R6: A command that arrives in the cycle after its own port accepted a command is ignored. A write command during beat 1 writes nothing at its address. A read command during the fetch cycle produces no extra beats.
- R7: Read commands issued every second cycle produce an unbroken stream of valid beats. Write commands issued every second cycle are all committed.
- R8: A read accepted in cycle N returns the effect of every write whose command cycle is N or earlier. This includes a write accepted in cycle N itself, with its lane masking applied. A write whose command cycle is N+1 or later is not visible to that read.
- R9: The data width is LANES*9 bits, with one lane enable per 9-bit lane. The array depth is 2**ADDR_W words of twice the data width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cmd | input | 1 | Start a two-beat read |
| rd_addr | input | ADDR_W | Word address of the read |
| wr_cmd | input | 1 | Start a two-beat write; this cycle carries beat 0 |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | LANES*9 | Write beat data |
| wr_be | input | LANES | Per-lane enables, sampled with each beat |
| rd_data | output | LANES*9 | Registered read beat data |
| rd_valid | output | 1 | High while a read beat is on rd_data |

Write-port states: WR_IDLE moves to WR_SECOND when a command arrives. WR_SECOND always returns to WR_IDLE, and the commit happens on that edge.

Read-port states: RD_IDLE moves to RD_FETCH when a command arrives. RD_FETCH always moves to RD_SEND. RD_SEND moves to RD_FETCH when a command arrives, and to RD_IDLE otherwise.

## Verification
Several properties are checked on every cycle:
- the zero output when not valid;
- the fixed two-cycle latency to the first read beat, and that valid stays high through the second beat;
- the gap of at least one cycle between commits;
- that an array write changes exactly the enabled lanes.

Other behaviours can only be shown by the bench's scenarios:
- that the returned data matches what was written;
- that forwarding picks the right address and applies the beat-1 enables;
- that ignored commands leave other addresses untouched;
- the ordering boundary between a read and a write one cycle apart.

// File: rtl/b2_sram_pkg.sv
`timescale 1ns/1ps
package b2_sram_pkg;
    localparam int LANE_BITS = 9;

    typedef enum logic [0:0] {
        WR_IDLE,
        WR_SECOND
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_FETCH,
        RD_SEND
    } rd_state_e;
endpackage

// File: rtl/b2_wr_collect.sv
`timescale 1ns/1ps
module b2_wr_collect
    import b2_sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_cmd,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [LANES*LANE_BITS-1:0]    wr_data,
    input  logic [LANES-1:0]              wr_be,
    output logic                          commit_en,
    output logic [ADDR_W-1:0]             commit_addr,
    output logic [2*LANES*LANE_BITS-1:0]  commit_data,
    output logic [2*LANES*LANE_BITS-1:0]  commit_mask
);
    localparam int W = LANES * LANE_BITS;

    wr_state_e          state_q, state_d;
    logic [W-1:0]       beat0_q;
    logic [LANES-1:0]   be0_q;
    logic [ADDR_W-1:0]  addr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE:   if (wr_cmd) state_d = WR_SECOND;
            WR_SECOND: state_d = WR_IDLE;
            default:   state_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat0_q <= '0;
            be0_q   <= '0;
            addr_q  <= '0;
        end else if (state_q == WR_IDLE && wr_cmd) begin
            beat0_q <= wr_data;
            be0_q   <= wr_be;
            addr_q  <= wr_addr;
        end
    end

    assign commit_en   = (state_q == WR_SECOND);
    assign commit_addr = addr_q;
    assign commit_data = {wr_data, beat0_q};

    for (genvar i = 0; i < LANES; i++) begin : g_lane_mask
        assign commit_mask[i*LANE_BITS +: LANE_BITS]     = {LANE_BITS{be0_q[i]}};
        assign commit_mask[W + i*LANE_BITS +: LANE_BITS] = {LANE_BITS{wr_be[i]}};
    end

    // R2
    accept_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WR_IDLE && wr_cmd) |=> (commit_en && commit_addr == $past(wr_addr)));

    // R6
    commit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> !commit_en);
endmodule

// File: rtl/b2_array.sv
`timescale 1ns/1ps
module b2_array #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] wmask,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rword
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
    end

    // forward a write committing in the fetch cycle to the same word
    always_comb begin
        rword = mem[raddr];
        if (we && waddr == raddr) rword = (rword & ~wmask) | (wdata & wmask);
    end

    // R3
    keep_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem[$past(waddr)] & ~$past(wmask)) == ($past(mem[waddr]) & ~$past(wmask))));

    // R2
    set_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem[$past(waddr)] & $past(wmask)) == ($past(wdata) & $past(wmask))));
endmodule

// File: rtl/b2_rd_pipe.sv
`timescale 1ns/1ps
module b2_rd_pipe
    import b2_sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_cmd,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [ADDR_W-1:0]             fetch_addr,
    input  logic [2*LANES*LANE_BITS-1:0]  fetch_word,
    output logic [LANES*LANE_BITS-1:0]    rd_data,
    output logic                          rd_valid
);
    localparam int W = LANES * LANE_BITS;

    rd_state_e          state_q, state_d;
    logic [ADDR_W-1:0]  addr_q;
    logic [W-1:0]       hi_q;
    logic               accept;

    assign accept = rd_cmd && (state_q != RD_FETCH);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  if (rd_cmd) state_d = RD_FETCH;
            RD_FETCH: state_d = RD_SEND;
            RD_SEND:  state_d = rd_cmd ? RD_FETCH : RD_IDLE;
            default:  state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            hi_q     <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (accept) addr_q <= rd_addr;
            unique case (state_q)
                RD_FETCH: begin
                    rd_data  <= fetch_word[W-1:0];
                    hi_q     <= fetch_word[2*W-1:W];
                    rd_valid <= 1'b1;
                end
                RD_SEND: begin
                    rd_data  <= hi_q;
                    rd_valid <= 1'b1;
                end
                default: begin
                    rd_data  <= '0;
                    rd_valid <= 1'b0;
                end
            endcase
        end
    end

    assign fetch_addr = addr_q;

    // R4
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##2 rd_valid);

    // R4
    second_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && state_q == RD_SEND) |=> rd_valid);

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));
endmodule

// File: rtl/b2_sram.sv
`timescale 1ns/1ps
module b2_sram
    import b2_sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_cmd,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic                        wr_cmd,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [LANES*LANE_BITS-1:0]  wr_data,
    input  logic [LANES-1:0]            wr_be,
    output logic [LANES*LANE_BITS-1:0]  rd_data,
    output logic                        rd_valid
);
    localparam int W  = LANES * LANE_BITS;
    localparam int WW = 2 * W;

    logic              commit_en;
    logic [ADDR_W-1:0] commit_addr;
    logic [WW-1:0]     commit_data;
    logic [WW-1:0]     commit_mask;
    logic [ADDR_W-1:0] fetch_addr;
    logic [WW-1:0]     fetch_word;

    b2_wr_collect #(.LANES(LANES), .ADDR_W(ADDR_W)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_cmd      (wr_cmd),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_be       (wr_be),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .commit_mask (commit_mask)
    );

    b2_array #(.ADDR_W(ADDR_W), .WORD_W(WW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit_en),
        .waddr (commit_addr),
        .wdata (commit_data),
        .wmask (commit_mask),
        .raddr (fetch_addr),
        .rword (fetch_word)
    );

    b2_rd_pipe #(.LANES(LANES), .ADDR_W(ADDR_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_cmd     (rd_cmd),
        .rd_addr    (rd_addr),
        .fetch_addr (fetch_addr),
        .fetch_word (fetch_word),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );
endmodule

// File: tb/test_b2_sram.sv
`timescale 1ns/1ps
module test_b2_sram;
    localparam int LANES  = 4;
    localparam int ADDR_W = 6;
    localparam int W      = LANES * 9;

    typedef struct {
        int           at;
        logic [W-1:0] d;
        string        tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_cmd = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              wr_cmd = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [W-1:0]      wr_data = '0;
    logic [LANES-1:0]  wr_be = '0;
    logic [W-1:0]      rd_data;
    logic              rd_valid;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    exp_t q[$];
    logic [2*W-1:0] model [1 << ADDR_W];

    // bench-side port state, derived from the command spacing rules
    bit               w_sec = 0;
    logic [W-1:0]     w_b0;
    logic [LANES-1:0] w_be0;
    logic [ADDR_W-1:0] w_a;
    bit               r_fetch = 0;
    logic [ADDR_W-1:0] r_a;
    string            r_tag;

    b2_sram #(.LANES(LANES), .ADDR_W(ADDR_W)) i_b2_sram (
        .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .rd_addr(rd_addr),
        .wr_cmd(wr_cmd), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] nw,
                                           logic [LANES-1:0] be);
        logic [W-1:0] r = old;
        for (int i = 0; i < LANES; i++)
            if (be[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    function automatic logic [W-1:0] rnd();
        return W'({$urandom(), $urandom()});
    endfunction

    task automatic check(bit ok, string tag, logic v, logic [W-1:0] d,
                         logic ev, logic [W-1:0] ed);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cyc=%0d actual valid=%b data=%h expected valid=%b data=%h",
                     tag, cyc, v, d, ev, ed);
        end
    endtask

    // driver: one call is one clock cycle
    task automatic step(bit rd, logic [ADDR_W-1:0] ra, bit wr, logic [ADDR_W-1:0] wa,
                        logic [W-1:0] wd, logic [LANES-1:0] be, string tag);
        @(negedge clk);
        if (w_sec) begin
            model[w_a][W-1:0]   = merge(model[w_a][W-1:0], w_b0, w_be0);
            model[w_a][2*W-1:W] = merge(model[w_a][2*W-1:W], wd, be);
            w_sec = 0;
        end else if (wr) begin
            w_b0 = wd; w_be0 = be; w_a = wa; w_sec = 1;
        end
        if (r_fetch) begin
            q.push_back('{cyc + 1, model[r_a][W-1:0], r_tag});
            q.push_back('{cyc + 2, model[r_a][2*W-1:W], r_tag});
            r_fetch = 0;
        end else if (rd) begin
            r_a = ra; r_tag = tag; r_fetch = 1;
        end
        rd_cmd = rd; rd_addr = ra; wr_cmd = wr; wr_addr = wa; wr_data = wd; wr_be = be;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0, '0, '0, "");
    endtask

    task automatic wfull(logic [ADDR_W-1:0] a);
        step(0, '0, 1, a, rnd(), '1, "");
        step(0, '0, 0, '0, rnd(), '1, "");
    endtask

    task automatic rd1(logic [ADDR_W-1:0] a, string tag);
        step(1, a, 0, '0, '0, '0, tag);
        idle(3);
    endtask

    // monitor: compares the scoreboard queue with the read port
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (q.size() > 0 && q[0].at == cyc) begin
                check(rd_valid === 1'b1 && rd_data === q[0].d, q[0].tag,
                      rd_valid, rd_data, 1'b1, q[0].d);
                void'(q.pop_front());
            end else begin
                // R1 R6: no beat expected, output must be idle and zero
                check(rd_valid === 1'b0 && rd_data === '0, "R1/R6 idle",
                      rd_valid, rd_data, 1'b0, '0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs during reset
        check(rd_valid === 1'b0 && rd_data === '0, "R1 reset", rd_valid, rd_data, 1'b0, '0);
        rst_n = 1'b1;
        idle(2);

        // R2 R9: full-lane writes, then reads of each word
        for (int a = 0; a < 8; a++) wfull(ADDR_W'(a));
        wfull(20); wfull(21);
        idle(2);
        for (int a = 0; a < 8; a++) rd1(ADDR_W'(a), "R2 R4 full write/read");

        // R3: different lane enables on each beat
        step(0, '0, 1, 3, rnd(), 4'b0101, "");
        step(0, '0, 0, '0, rnd(), 4'b1010, "");
        step(0, '0, 1, 4, rnd(), 4'b0000, "");
        step(0, '0, 0, '0, rnd(), 4'b1000, "");
        idle(1);
        rd1(3, "R3 lane mask");
        rd1(4, "R3 lane mask sparse");

        // R5: read and write with separate addresses in one cycle
        step(1, 1, 1, 10, rnd(), '1, "R5 concurrent read");
        step(0, '0, 0, '0, rnd(), '1, "");
        idle(3);
        rd1(10, "R5 concurrent write");

        // R6: write command during beat 1 ignored; read during fetch ignored
        step(0, '0, 1, 5, rnd(), '1, "");
        step(0, '0, 1, 20, rnd(), '1, "");
        idle(1);
        rd1(20, "R6 ignored write");
        step(1, 2, 0, '0, '0, '0, "R6 read");
        step(1, 6, 0, '0, '0, '0, "R6 ignored read");
        idle(4);
        rd1(5, "R6 beat1 data");

        // R7: back-to-back reads and writes every second cycle
        for (int i = 0; i < 8; i++) begin
            step(1, ADDR_W'(i), 1, ADDR_W'(30 + i), rnd(), '1, "R7 stream");
            step(0, '0, 0, '0, rnd(), '1, "");
        end
        idle(3);
        for (int i = 0; i < 8; i++) begin
            step(1, ADDR_W'(30 + i), 0, '0, '0, '0, "R7 stream writes");
            idle(1);
        end
        idle(3);

        // R8: read in the write's command cycle sees the masked new data
        step(1, 3, 1, 3, rnd(), 4'b0011, "R8 same-cycle write");
        step(0, '0, 0, '0, rnd(), 4'b1100, "");
        idle(3);
        // R8: read during beat 1 of an earlier write sees it
        step(0, '0, 1, 7, rnd(), 4'b1110, "");
        step(1, 7, 0, '0, rnd(), 4'b0111, "R8 write in flight");
        idle(4);
        // R8: write issued one cycle after the read stays invisible to it
        step(1, 21, 0, '0, '0, '0, "R8 later write");
        step(0, '0, 1, 21, rnd(), '1, "");
        step(0, '0, 0, '0, rnd(), '1, "");
        idle(3);
        rd1(21, "R8 later write landed");
        idle(4);

        if (q.size() != 0)
            check(0, "R4 missing beats", 1'b0, '0, 1'b1, '0);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule